// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Order

This block produces the word address stream for a four-beat memory burst. A burst opens when either of two start strobes is high at a rising clock edge. One strobe comes from the processor and one from the cache controller. At that edge the complete external address is latched. Later beats are made inside the block. A 2-bit beat counter moves forward by one on each clock edge where the advance input is high. The counter supplies the two low address bits, and the upper bits keep the latched value.

The order select input decides how the low bits follow the beat count. When it is low, the order is linear: the start value plus the beat count, modulo four. When it is high, the order is interleaved: the start value XOR the beat count. At board level this input is normally pulled high when left open, so interleaved order is the default in practice. Inside the block the input is a plain pin, and the surrounding logic must drive it.

All inputs are sampled on the rising edge of one clock. The address and the burst-active flag come from registered state. They only pass through the order mapping, which reads the static select input. The ports carry no data stream, so there is no valid/ready handshake. Every pin is a plain control or status signal, and the block never applies back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low and after it is released, `addr_out` is all zeros and `burst_active` is 0 until the first start strobe.
- R2: A rising edge with `proc_strobe` or `cache_strobe` high latches `addr_in`. From the next cycle, `addr_out` equals that latched address and `burst_active` is 1.
- R3: A start strobe reloads the address and clears the beat count even when a burst is running. It takes precedence over `advance`. Both strobes high together act the same as one strobe.
- R4: With `order_sel` = 0 (linear), the low two bits of `addr_out` at beat k are (s + k) mod 4, where s is the latched low two bits. Example: start 1 gives 1, 2, 3, 0.
- R5: With `order_sel` = 1 (interleaved), the low two bits at beat k are s XOR k. Example: start 1 gives 1, 0, 3, 2.
- R6: During a burst, `addr_out[ADDR_W-1:2]` always equals the latched upper address bits, for every beat and in both orders.
- R7: The beat count steps only on an edge where `advance` is high and no strobe is high. An edge with neither a strobe nor `advance` leaves `addr_out` and `burst_active` unchanged.
- R8: Advancing from the fourth beat (k = 3) clears `burst_active`. The counter wraps to 0, so `addr_out` returns to the latched start address and stays there.
- R9: While `burst_active` is 0, `advance` has no effect on `addr_out` or `burst_active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_strobe | input | 1 | Burst start request from the processor |
| cache_strobe | input | 1 | Burst start request from the cache controller |
| advance | input | 1 | Step to the next beat of the running burst |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | External word address, latched on a strobe |
| addr_out | output | ADDR_W | Current burst word address |
| burst_active | output | 1 | High from a strobe until the fourth beat is advanced past |

## Verification
The properties assume that `order_sel` only changes at the same edge as a start strobe or while no burst is running. Under that assumption, a change of order never moves `addr_out` on a hold edge. The stimulus changes the select input only while the burst is idle or in the same cycle as a strobe. Between such changes it holds the input constant for the whole burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int unsigned BEAT_W = 2;
  localparam int unsigned BEATS  = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2
  } seq_cmd_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_seq_pkg::*;
(
  input  logic     proc_req,
  input  logic     cache_req,
  input  logic     step_req,
  input  logic     running,
  output seq_cmd_e cmd
);

  // A start request from either side wins over a step request.
  // A step is only honoured inside a running burst.
  always_comb begin
    if (proc_req || cache_req) begin
      cmd = CMD_LOAD;
    end else if (step_req && running) begin
      cmd = CMD_STEP;
    end else begin
      cmd = CMD_HOLD;
    end
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_cmd_e          cmd,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] base_addr,
  output beat_t             beat,
  output logic              running
);

  localparam beat_t LAST_BEAT = beat_t'(BEATS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      beat      <= '0;
      running   <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          base_addr <= load_addr;
          beat      <= '0;
          running   <= 1'b1;
        end
        CMD_STEP: begin
          beat <= beat + beat_t'(1);
          if (beat == LAST_BEAT) begin
            running <= 1'b0;
          end
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  beat_t  start_lo,
  input  beat_t  beat,
  input  order_e order,
  output beat_t  addr_lo
);

  beat_t lin_lo;
  beat_t ilv_lo;

  assign lin_lo = start_lo + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
    assign ilv_lo[b] = start_lo[b] ^ beat[b];
  end

  always_comb begin
    if (order == ORDER_INTERLEAVE) begin
      addr_lo = ilv_lo;
    end else begin
      addr_lo = lin_lo;
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe,
  input  logic              cache_strobe,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);

  seq_cmd_e          cmd;
  logic [ADDR_W-1:0] base_addr;
  beat_t             beat;
  beat_t             mapped_lo;
  logic              running;

  burst_cmd_decode u_dec (
    .proc_req  (proc_strobe),
    .cache_req (cache_strobe),
    .step_req  (advance),
    .running   (running),
    .cmd       (cmd)
  );

  burst_beat_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .load_addr (addr_in),
    .base_addr (base_addr),
    .beat      (beat),
    .running   (running)
  );

  burst_order_map u_map (
    .start_lo (base_addr[BEAT_W-1:0]),
    .beat     (beat),
    .order    (order_e'(order_sel)),
    .addr_lo  (mapped_lo)
  );

  assign addr_out     = {base_addr[ADDR_W-1:BEAT_W], mapped_lo};
  assign burst_active = running;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_strobe,
  input logic              cache_strobe,
  input logic              advance,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_active
);

  logic unused_ok;
  assign unused_ok = order_sel;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe || cache_strobe) |=> (addr_out == $past(addr_in)) && burst_active);

  assert_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !proc_strobe && !cache_strobe) |=>
      addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !proc_strobe && !cache_strobe) |=>
      $stable(addr_out) && $stable(burst_active));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_active && !proc_strobe && !cache_strobe) |=>
      $stable(addr_out) && !burst_active);

  assert_linear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && advance && !proc_strobe && !cache_strobe && !order_sel) |=>
      addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (addr_out == '0) && !burst_active);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .proc_strobe  (proc_strobe),
  .cache_strobe (cache_strobe),
  .advance      (advance),
  .order_sel    (order_sel),
  .addr_in      (addr_in),
  .addr_out     (addr_out),
  .burst_active (burst_active)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

  localparam int unsigned AW = 20;

  typedef struct {
    logic [AW-1:0] addr;
    logic          act;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proc_strobe = 1'b0;
  logic          cache_strobe = 1'b0;
  logic          advance = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          burst_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_act  = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .proc_strobe  (proc_strobe),
    .cache_strobe (cache_strobe),
    .advance      (advance),
    .order_sel    (order_sel),
    .addr_in      (addr_in),
    .addr_out     (addr_out),
    .burst_active (burst_active)
  );

  function automatic logic [AW-1:0] model_addr(input logic mode);
    logic [1:0] lo;
    lo = mode ? (m_base[1:0] ^ m_beat) : 2'(m_base[1:0] + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] a, input logic v,
                       input logic [AW-1:0] ea, input logic ev);
    checks++;
    if (a !== ea || v !== ev) begin
      errors++;
      $display("FAIL %s: addr=%h active=%b expected addr=%h active=%b", req, a, v, ea, ev);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(input logic ps, input logic cs, input logic adv,
                       input logic mode, input logic [AW-1:0] a, input string req);
    exp_t e;
    @(negedge clk);
    proc_strobe  = ps;
    cache_strobe = cs;
    advance      = adv;
    order_sel    = mode;
    addr_in      = a;
    if (ps || cs) begin
      m_base = a;
      m_beat = 2'd0;
      m_act  = 1'b1;
    end else if (adv && m_act) begin
      if (m_beat == 2'd3) m_act = 1'b0;
      m_beat = 2'(m_beat + 2'd1);
    end
    e.addr = model_addr(mode);
    e.act  = m_act;
    e.req  = req;
    sb_q.push_back(e);
  endtask

  // Monitor: compares after each edge that has a queued expectation.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.req, addr_out, burst_active, e.addr, e.act);
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", addr_out, burst_active, '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", addr_out, burst_active, '0, 1'b0);

    // R9: advance while idle is ignored
    drive(0, 0, 1, 0, 20'hAAAAA, "R9 idle advance");

    // R2/R4/R6/R8: processor strobe, linear, start 1
    drive(1, 0, 0, 0, 20'h12345, "R2 proc load");
    drive(0, 0, 1, 0, 20'h0, "R4 linear beat1");
    drive(0, 0, 1, 0, 20'h0, "R4 linear beat2");
    drive(0, 0, 0, 0, 20'h0, "R7 hold mid burst");
    drive(0, 0, 1, 0, 20'h0, "R4 linear beat3 R6");
    drive(0, 0, 1, 0, 20'h0, "R8 wrap and end");
    drive(0, 0, 1, 0, 20'h0, "R9 advance after end");

    // R5: cache strobe, interleaved, start 1 -> 1,0,3,2
    drive(0, 1, 0, 1, 20'hF00F1, "R2 cache load");
    drive(0, 0, 1, 1, 20'h0, "R5 interleave beat1");
    drive(0, 0, 1, 1, 20'h0, "R5 interleave beat2");
    drive(0, 0, 1, 1, 20'h0, "R5 interleave beat3");
    drive(0, 0, 1, 1, 20'h0, "R8 interleave end");

    // R3: restart mid burst with advance also high, then both strobes
    drive(1, 0, 0, 1, 20'h0ABC2, "R2 load start 2");
    drive(0, 0, 1, 1, 20'h0, "R5 interleave from 2");
    drive(0, 1, 1, 1, 20'h55557, "R3 reload beats advance");
    drive(0, 0, 1, 1, 20'h0, "R5 interleave from 3");
    drive(1, 1, 0, 1, 20'h7777E, "R3 both strobes");
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 1, 20'h0, "R5 full burst from 2");

    // R4: linear from start 3 -> 3,0,1,2
    drive(0, 1, 0, 0, 20'hC3C3B, "R2 load start 3");
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 20'h0, "R4 linear from 3");
    drive(0, 0, 0, 0, 20'h0, "R7 hold beat3");
    drive(0, 0, 1, 0, 20'h0, "R8 linear end");
    drive(0, 0, 0, 0, 20'h0, "R7 idle hold");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule